// File: doc/BRIEF.md
# Serial LCD Command/Data Receiver

This block is the write-only front end of a segment LCD controller. A host drives four wires: a shift clock, an active-low select, a data line and a command/data select line. The block brings all four into the system clock domain through multi-stage synchronisers and detects edges there, so the system clock must run at least four times faster than the shift clock. While the select is low, each rising shift-clock edge shifts one data bit into an 8-bit byte, most significant bit first.

On the eighth rising edge of a byte, the block reads the command/data select line to classify the byte. A command byte leaves on a one-cycle strobe together with its value, for an external decoder to act on. A display byte is stored in a 128-bit display memory (32 segments by 4 commons) at the byte slot given by an address counter. The counter then advances by one slot and wraps at the end of the memory. A combinational read port lets the scan logic fetch the four common bits of any segment.

Top module: `lcd_serial_rx`

## Requirements
- R1: Bits are assembled most significant bit first; the first bit shifted in a byte becomes bit 7 of that byte.
- R2: The data line is sampled only on rising edges of the shift clock; data changes while the clock is high have no effect.
- R3: Shift-clock edges while the select is high assemble nothing: no command strobe and no memory write result.
- R4: When the select rises part way through a byte, the partial byte is dropped. The next byte after the select falls again starts at bit 7.
- R5: If the command/data line is high at the eighth edge, `cmd_valid` is high for exactly one cycle with the byte on `cmd_byte`, and the display memory is unchanged.
- R6: If the command/data line is low at the eighth edge, the byte is written to byte slot k of the memory. Bit j of the byte lands at linear bit 8k+j. Segment s reads linear bits 4s+3..4s on `rd_coms`, with common c on bit c. A 1 bit means the segment is shown at that common.
- R7: Each display byte advances the slot counter by one, and it wraps from slot 15 to slot 0. Command bytes leave it unchanged.
- R8: The command/data line matters only at the eighth edge; its level on edges one to seven has no effect.
- R9: Several bytes may be sent within one low period of the select, each classified at its own eighth edge.
- R10: Active-low reset clears the slot counter to 0 and clears the memory to all blank, and `cmd_valid` is low during and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shift_clk | input | 1 | Serial shift clock, asynchronous |
| sel_n | input | 1 | Active-low serial select, asynchronous |
| ser_data | input | 1 | Serial data line |
| cmd_sel | input | 1 | High marks a command byte, low a display byte |
| rd_seg | input | 5 | Segment index for the scan read port |
| cmd_valid | output | 1 | One-cycle strobe for a received command byte |
| cmd_byte | output | 8 | Value of the command byte |
| rd_coms | output | 4 | Common bits of segment `rd_seg` |

## Verification
The bench first drops the select part way through a byte and then sends a whole command. A receiver that keeps its bit count across the select would report a shifted, wrong command value. It toggles the data line while the clock is high and holds the command/data line high for the first seven bits of display bytes. A design sampling on the wrong edge or latching the class early would then store wrong bytes or raise a false command. It writes seventeen display bytes to reach the slot wrap; a counter with the wrong width or no wrap would overwrite the wrong slot. It also clocks whole bytes with the select high, and a missing qualifier would then show up as a stray strobe or memory change.

// File: rtl/lcdrx_pkg.sv
package lcdrx_pkg;
   localparam int unsigned LCDRX_BYTE_BITS = 8;

   typedef enum logic {
      KIND_DATA = 1'b0,
      KIND_CMD  = 1'b1
   } byte_kind_e;
endpackage

// File: rtl/lcdrx_sync.sv
module lcdrx_sync #(
   parameter int unsigned WIDTH   = 4,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   logic [WIDTH-1:0] stg [STAGES];

   initial begin
      assert (STAGES >= 2) else $error("lcdrx_sync: STAGES must be at least 2");
      assert (WIDTH >= 1) else $error("lcdrx_sync: WIDTH must be at least 1");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/lcdrx_framer.sv
module lcdrx_framer
   import lcdrx_pkg::*;
#(
   parameter int unsigned BYTE_W = LCDRX_BYTE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              seln_s,
   input  logic              sd_s,
   input  logic              cd_s,
   output logic              byte_done,
   output byte_kind_e        byte_kind,
   output logic [BYTE_W-1:0] byte_val
);
   localparam int unsigned CW = $clog2(BYTE_W);
   localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);

   logic              sclk_q, seln_q;
   logic              sclk_rise, sel_fall;
   logic [CW-1:0]     bit_cnt, cnt_base;
   logic [BYTE_W-1:0] shreg, sh_next;

   initial begin
      assert (BYTE_W >= 2 && (1 << CW) == BYTE_W)
         else $error("lcdrx_framer: BYTE_W must be a power of two");
   end

   assign sclk_rise = sclk_s & ~sclk_q;
   assign sel_fall  = seln_q & ~seln_s;
   assign cnt_base  = sel_fall ? '0 : bit_cnt;
   assign sh_next   = {shreg[BYTE_W-2:0], sd_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         seln_q <= 1'b1;
      end else begin
         sclk_q <= sclk_s;
         seln_q <= seln_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         shreg     <= '0;
         byte_done <= 1'b0;
         byte_kind <= KIND_DATA;
         byte_val  <= '0;
      end else begin
         byte_done <= 1'b0;
         if (seln_s) begin
            bit_cnt <= '0;
         end else if (sclk_rise) begin
            shreg <= sh_next;
            if (cnt_base == LAST_BIT) begin
               bit_cnt   <= '0;
               byte_done <= 1'b1;
               byte_kind <= cd_s ? KIND_CMD : KIND_DATA;
               byte_val  <= sh_next;
            end else begin
               bit_cnt <= cnt_base + 1'b1;
            end
         end else if (sel_fall) begin
            bit_cnt <= '0;
         end
      end
   end

   // R3 R4: a high select leaves the framer waiting at bit 7
   a_r4_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
      seln_s |=> (bit_cnt == '0));

   // R3: no byte completes while the select is high
   a_r3_no_byte_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $past(seln_s) |-> !byte_done);

   // R5: a completed byte is a single-cycle event
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> !byte_done);
endmodule

// File: rtl/lcdrx_dram.sv
module lcdrx_dram #(
   parameter int unsigned NUM_SEG = 32,
   parameter int unsigned NUM_COM = 4,
   parameter int unsigned BYTE_W  = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [BYTE_W-1:0]          wr_data,
   input  logic [$clog2(NUM_SEG)-1:0] rd_seg,
   output logic [NUM_COM-1:0]         rd_coms
);
   localparam int unsigned BITS   = NUM_SEG * NUM_COM;
   localparam int unsigned NBYTES = BITS / BYTE_W;
   localparam int unsigned AW     = $clog2(NBYTES);
   localparam logic [AW-1:0] LAST_SLOT = AW'(NBYTES - 1);

   logic [AW-1:0]     slot;
   logic [BYTE_W-1:0] bank [NBYTES];
   logic [BITS-1:0]   flat;

   initial begin
      assert (NBYTES * BYTE_W == BITS)
         else $error("lcdrx_dram: memory size must be a whole number of bytes");
      assert (NBYTES >= 2 && (1 << AW) == NBYTES)
         else $error("lcdrx_dram: byte count must be a power of two of at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot <= '0;
      else if (wr_en) slot <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
   end

   for (genvar k = 0; k < NBYTES; k++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          bank[k] <= '0;
         else if (wr_en && slot == AW'(k))    bank[k] <= wr_data;
      end
      assign flat[k*BYTE_W +: BYTE_W] = bank[k];
   end

   assign rd_coms = flat[rd_seg*NUM_COM +: NUM_COM];

   // R7: the slot counter only moves on display writes
   a_r7_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(slot));

   // R7: a write always moves the slot counter
   a_r7_slot_moves: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !$stable(slot));

   // R6: the written slot holds the written byte afterwards
   a_r6_byte_stored: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (bank[$past(slot)] == $past(wr_data)));
endmodule

// File: rtl/lcd_serial_rx.sv
module lcd_serial_rx
   import lcdrx_pkg::*;
#(
   parameter int unsigned NUM_SEG     = 32,
   parameter int unsigned NUM_COM     = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       shift_clk,
   input  logic                       sel_n,
   input  logic                       ser_data,
   input  logic                       cmd_sel,
   input  logic [$clog2(NUM_SEG)-1:0] rd_seg,
   output logic                       cmd_valid,
   output logic [LCDRX_BYTE_BITS-1:0] cmd_byte,
   output logic [NUM_COM-1:0]         rd_coms
);
   localparam int unsigned BW = LCDRX_BYTE_BITS;

   logic [3:0]    pins_s;
   logic          done;
   byte_kind_e    kind;
   logic [BW-1:0] val;
   logic          data_wr;

   lcdrx_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0010)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({cmd_sel, ser_data, sel_n, shift_clk}),
      .q_sync  (pins_s)
   );

   lcdrx_framer #(.BYTE_W(BW)) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (pins_s[0]),
      .seln_s    (pins_s[1]),
      .sd_s      (pins_s[2]),
      .cd_s      (pins_s[3]),
      .byte_done (done),
      .byte_kind (kind),
      .byte_val  (val)
   );

   assign data_wr = done && (kind == KIND_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_byte  <= '0;
      end else begin
         cmd_valid <= done && (kind == KIND_CMD);
         if (done && kind == KIND_CMD) cmd_byte <= val;
      end
   end

   lcdrx_dram #(.NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .BYTE_W(BW)) u_dram (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (data_wr),
      .wr_data (val),
      .rd_seg  (rd_seg),
      .rd_coms (rd_coms)
   );

   // R5: command strobe lasts one cycle
   a_r5_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   // R5: a command byte from the framer appears on the strobe next cycle
   a_r5_cmd_value: assert property (@(posedge clk) disable iff (!rst_n)
      (done && kind == KIND_CMD) |=> (cmd_valid && cmd_byte == $past(val)));

   // R5 R6: a byte is either a command or a write, never both
   a_r6_no_cmd_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |=> !cmd_valid);
endmodule

// File: tb/lcd_serial_rx_bench.sv
module lcd_serial_rx_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       shift_clk = 1'b0;
   logic       sel_n = 1'b1;
   logic       ser_data = 1'b0;
   logic       cmd_sel = 1'b0;
   logic [4:0] rd_seg = '0;
   logic       cmd_valid;
   logic [7:0] cmd_byte;
   logic [3:0] rd_coms;

   int n_checks = 0;
   int n_fail = 0;
   int cmd_cnt = 0;
   logic [7:0] last_cmd = '0;
   logic [7:0] shadow [16];
   int waddr = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   lcd_serial_rx u_lcd_serial_rx (
      .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .sel_n(sel_n),
      .ser_data(ser_data), .cmd_sel(cmd_sel), .rd_seg(rd_seg),
      .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .rd_coms(rd_coms)
   );

   always @(negedge clk) begin
      if (cmd_valid) begin
         cmd_cnt  <= cmd_cnt + 1;
         last_cmd <= cmd_byte;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic select(input bit low);
      @(negedge clk);
      sel_n = !low;
      wait_clks(6);
   endtask

   // one shift clock period; data set while low, optionally disturbed while high
   task automatic shift_bit(input bit b, input bit cd, input bit disturb);
      @(negedge clk);
      ser_data = b;
      cmd_sel  = cd;
      wait_clks(4);
      shift_clk = 1'b1;
      wait_clks(4);
      if (disturb) begin
         ser_data = ~b;
         cmd_sel  = ~cd;
      end
      wait_clks(2);
      shift_clk = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v, input bit cd8, input bit cd_early,
                            input bit disturb);
      for (int i = 7; i >= 0; i--)
         shift_bit(v[i], (i == 0) ? cd8 : cd_early, disturb);
      wait_clks(8);
   endtask

   task automatic model_write(input logic [7:0] v);
      shadow[waddr] = v;
      waddr = (waddr + 1) % 16;
   endtask

   task automatic check_ram(input string tag);
      bit ok = 1;
      int bad_seg = -1;
      logic [3:0] act = '0, exp = '0;
      for (int s = 0; s < 32; s++) begin
         @(negedge clk);
         rd_seg = 5'(s);
         #1;
         exp = shadow[s/2][(s%2)*4 +: 4];
         if (ok && rd_coms !== exp) begin
            ok = 0; bad_seg = s; act = rd_coms;
         end
      end
      check(ok, tag, int'(act), int'(exp));
      if (!ok) $display("  (segment %0d)", bad_seg);
   endtask

   task automatic t_reset;
      check(cmd_valid === 1'b0, "R10 cmd_valid low after reset", int'(cmd_valid), 0);
      check_ram("R10 memory blank after reset");
   endtask

   task automatic t_commands;
      int c0 = cmd_cnt;
      select(1);
      send_byte(8'hB4, 1, 1, 0);
      check(cmd_cnt == c0 + 1, "R5 one strobe per command", cmd_cnt - c0, 1);
      check(last_cmd == 8'hB4, "R1 R5 command value MSB first", last_cmd, 8'hB4);
      send_byte(8'h01, 1, 0, 1);
      check(last_cmd == 8'h01 && cmd_cnt == c0 + 2, "R2 R9 second command in same select",
            last_cmd, 8'h01);
      select(0);
      check_ram("R5 commands leave memory untouched");
   endtask

   task automatic t_data;
      int c0 = cmd_cnt;
      select(1);
      send_byte(8'hA5, 0, 0, 0); model_write(8'hA5);
      send_byte(8'h3C, 0, 1, 1); model_write(8'h3C);
      send_byte(8'h81, 0, 1, 0); model_write(8'h81);
      select(0);
      check(cmd_cnt == c0, "R8 early command level gives no strobe", cmd_cnt - c0, 0);
      check_ram("R6 R8 R2 display bytes stored by slot");
      @(negedge clk); rd_seg = 5'd0; #1;
      check(rd_coms == 4'h5, "R6 segment 0 low nibble of slot 0", rd_coms, 5);
      @(negedge clk); rd_seg = 5'd1; #1;
      check(rd_coms == 4'hA, "R6 segment 1 high nibble of slot 0", rd_coms, 10);
   endtask

   task automatic t_deselected;
      int c0 = cmd_cnt;
      send_byte(8'hFF, 1, 1, 0);
      send_byte(8'h77, 0, 0, 0);
      check(cmd_cnt == c0, "R3 no strobe while deselected", cmd_cnt - c0, 0);
      check_ram("R3 no write while deselected");
   endtask

   task automatic t_partial;
      int c0 = cmd_cnt;
      select(1);
      shift_bit(1, 1, 0); shift_bit(0, 1, 0); shift_bit(1, 1, 0);
      select(0);
      check(cmd_cnt == c0, "R4 partial byte gives no strobe", cmd_cnt - c0, 0);
      select(1);
      send_byte(8'h6E, 1, 1, 0);
      select(0);
      check(cmd_cnt == c0 + 1 && last_cmd == 8'h6E, "R4 realigned after reselect",
            last_cmd, 8'h6E);
      check_ram("R4 partial byte not written");
   endtask

   task automatic t_wrap;
      select(1);
      for (int i = 0; i < 17; i++) begin
         send_byte(8'(8'h10 + i * 7), 0, 0, 0);
         model_write(8'(8'h10 + i * 7));
      end
      select(0);
      check_ram("R7 slot counter wraps 15 to 0");
   endtask

   task automatic t_reset_mid;
      select(1);
      send_byte(8'hC3, 0, 0, 0);
      select(0);
      @(negedge clk); rst_n = 1'b0;
      wait_clks(4);
      check(cmd_valid === 1'b0, "R10 cmd_valid low in reset", int'(cmd_valid), 0);
      @(negedge clk); rst_n = 1'b1;
      for (int k = 0; k < 16; k++) shadow[k] = '0;
      waddr = 0;
      check_ram("R10 memory cleared by reset");
      select(1);
      send_byte(8'h9D, 0, 0, 0); model_write(8'h9D);
      select(0);
      check_ram("R10 R7 slot counter back at 0");
   endtask

   initial begin
      for (int k = 0; k < 16; k++) shadow[k] = '0;
      wait_clks(5);
      rst_n = 1'b1;
      wait_clks(4);
      t_reset();
      t_commands();
      t_data();
      t_deselected();
      t_partial();
      t_wrap();
      t_reset_mid();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=expired expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end
endmodule